// File: doc/BRIEF.md
# Paged Nonvolatile Write Controller

This block is the write engine behind a byte-wide paged nonvolatile memory that presents an SRAM-like interface. The interface has an address, a data byte, and active-low chip enable, output enable and write enable. All of them are sampled on a system clock. A write strobe is a stretch of cycles in which chip enable and write enable are both low while output enable is high. Each strobe places one byte into a page buffer, and a mask records which positions of that buffer hold loaded bytes.

The first byte opens a load window and fixes the page. Later bytes must target that same page. Each one must finish within a fixed number of clock cycles after the previous accepted byte. When that idle limit runs out, the window closes and a timed programming period begins. At the end of that period the loaded bytes, and only those, are copied into the behavioural memory array.

Both durations are parameters counted in clock cycles. While the engine is busy, it refuses new write strobes and it blanks read data.

Top module: `pageWriteEngine`

## Requirements
- R1: After reset `busy` and `pageErr` are 0, and every array location reads back as 0x00.
- R2: A write strobe is a run of cycles with `ceN`=0, `weN`=0 and `oeN`=1. The address is taken in the first cycle of the run and the data in its last cycle. A cycle with `ceN`=0 and `weN`=0 but `oeN`=0 is not a strobe and changes nothing.
- R3: `rdData` shows the array byte at `addr` when `ceN`=0, `oeN`=0, `weN`=1 and `busy`=0. In every other case it is 0x00.
- R4: `busy` rises one clock after the first accepted byte. It falls exactly LOAD_CYC+PROG_CYC clocks after the edge on which the last accepted byte ended.
- R5: A byte joins the open page if its strobe ends at most LOAD_CYC clocks after the end of the previous accepted byte. A byte that ends later arrives after programming has started and is dropped.
- R6: `addr[PAGE_W-1:0]` selects the byte within the page and the upper bits select the page. Bytes may be loaded in any order. A position loaded twice keeps its last value.
- R7: Programming changes only the loaded positions of the fixed page. Every other array byte keeps its value.
- R8: A byte whose page bits differ from those of the first byte is dropped. It sets `pageErr`, which stays at 1 until reset. It neither alters the buffer nor restarts the idle count.
- R9: Write strobes that begin or end while programming is under way have no effect on the array or on the timing of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address: page bits above, in-page offset below |
| wrData | input | DATA_W | Write data byte |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| rdData | output | DATA_W | Read data, 0 when not reading or when busy |
| busy | output | 1 | High from first accepted byte until programming ends |
| pageErr | output | 1 | Sticky flag for a byte aimed at a foreign page |

## Verification
The internal state of this block can only be observed through the length of `busy` and through read-back after programming. A stale loaded mask or a wrong page register shows up in the first read-back after commit, as bytes that are missing or that land in the wrong place. An idle or program counter that is off by one shifts the falling edge of `busy` by a clock, and a check made on the exact cycle sees that shift at once. A byte slipped in during programming, or a foreign-page byte taken as valid, shows up either as a corrupted array byte or as a lengthened busy period in the same burst.

// File: rtl/pwePkg.sv
package pwePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } engState_t;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic capAddr;   // first cycle of a write strobe
    logic holdData;  // strobe active: track data byte
    logic loadByte;  // place captured byte into page buffer
    logic setPage;   // fix page from captured address
    logic commit;    // copy loaded bytes to the array
    logic inProg;    // programming period under way
  } engCmd_t;

endpackage

// File: rtl/pweControl.sv
module pweControl
  import pwePkg::*;
#(
  parameter int LOAD_CYC = 37500,
  parameter int PROG_CYC = 2500000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    weN,
  input  logic    pageMatch,
  output engCmd_t cmd,
  output logic    busy,
  output logic    pageErr
);

  localparam int LCW = $clog2(LOAD_CYC + 1);
  localparam int PCW = $clog2(PROG_CYC + 1);
  localparam logic [LCW-1:0] LOAD_LAST = LCW'(LOAD_CYC - 1);
  localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_CYC - 1);

  engState_t state, nState;
  logic [LCW-1:0] idleCnt;
  logic [PCW-1:0] progCnt;
  logic strobe, strobeQ, armed;
  logic startEv, endEv, acceptEv, errEv;

  assign strobe  = !ceN && !weN && oeN;
  assign startEv = strobe && !strobeQ && (state != ST_PROG);
  assign endEv   = !strobe && strobeQ && armed && (state != ST_PROG);

  always_comb begin
    nState   = state;
    cmd      = '0;
    acceptEv = 1'b0;
    errEv    = 1'b0;
    cmd.capAddr  = startEv;
    cmd.holdData = strobe;
    cmd.inProg   = (state == ST_PROG);
    case (state)
      ST_IDLE: begin
        if (endEv) begin
          cmd.loadByte = 1'b1;
          cmd.setPage  = 1'b1;
          acceptEv     = 1'b1;
          nState       = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (endEv && pageMatch) begin
          cmd.loadByte = 1'b1;
          acceptEv     = 1'b1;
        end else begin
          errEv = endEv;
          if (idleCnt == LOAD_LAST) nState = ST_PROG;
        end
      end
      ST_PROG: begin
        if (progCnt == PROG_LAST) begin
          cmd.commit = 1'b1;
          nState     = ST_IDLE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      strobeQ <= 1'b0;
      armed   <= 1'b0;
      idleCnt <= '0;
      progCnt <= '0;
      pageErr <= 1'b0;
    end else begin
      state   <= nState;
      strobeQ <= strobe;
      if (startEv)      armed <= 1'b1;
      else if (!strobe) armed <= 1'b0;
      if (acceptEv)               idleCnt <= '0;
      else if (state == ST_LOAD)  idleCnt <= idleCnt + 1'b1;
      if (state != ST_PROG) progCnt <= '0;
      else                  progCnt <= progCnt + 1'b1;
      if (errEv) pageErr <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |=> pageErr); // R8

  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(progCnt) == PROG_LAST)); // R4

  AST_NO_ACCEPT_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadByte |=> busy); // R9

endmodule

// File: rtl/pweDatapath.sv
module pweDatapath
  import pwePkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              busy,
  input  engCmd_t           cmd,
  output logic              pageMatch,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PAGE_AW    = ADDR_W - PAGE_W;
  localparam int NUM_PAGES  = 1 << PAGE_AW;

  logic [ADDR_W-1:0]  addrQ;
  logic [DATA_W-1:0]  dataQ;
  logic [PAGE_AW-1:0] pageReg;
  logic [DATA_W-1:0]  pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loadedMask;
  logic [DATA_W-1:0]  memArr [NUM_PAGES][PAGE_BYTES];
  logic               rdSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      pageReg <= '0;
    end else begin
      if (cmd.capAddr)  addrQ   <= addr;
      if (cmd.holdData) dataQ   <= wrData;
      if (cmd.setPage)  pageReg <= addrQ[ADDR_W-1:PAGE_W];
    end
  end

  assign pageMatch = (addrQ[ADDR_W-1:PAGE_W] == pageReg);

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[i]    <= '0;
        loadedMask[i] <= 1'b0;
      end else if (cmd.commit) begin
        loadedMask[i] <= 1'b0;
      end else if (cmd.loadByte && (addrQ[PAGE_W-1:0] == PAGE_W'(i))) begin
        pageBuf[i]    <= dataQ;
        loadedMask[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++)
          memArr[p][b] <= '0;
    end else if (cmd.commit) begin
      for (int b = 0; b < PAGE_BYTES; b++)
        if (loadedMask[b]) memArr[pageReg][b] <= pageBuf[b];
    end
  end

  assign rdSel  = !ceN && !oeN && weN && !busy;
  assign rdData = rdSel ? memArr[addr[ADDR_W-1:PAGE_W]][addr[PAGE_W-1:0]] : '0;

  AST_LOAD_SAME_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadByte |-> (pageMatch || cmd.setPage)); // R8

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> (loadedMask == '0)); // R7

  AST_FROZEN_IN_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.inProg && !cmd.commit) |=> $stable(loadedMask)); // R9

  AST_COMMIT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |-> (loadedMask != '0)); // R4

endmodule

// File: rtl/pageWriteEngine.sv
module pageWriteEngine
  import pwePkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 8,
  parameter int DATA_W   = 8,
  parameter int LOAD_CYC = 37500,
  parameter int PROG_CYC = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              pageErr
);

  engCmd_t cmd;
  logic    pageMatch;

  pweControl #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pageMatch(pageMatch), .cmd(cmd), .busy(busy), .pageErr(pageErr)
  );

  pweDatapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .ceN(ceN), .oeN(oeN), .weN(weN), .busy(busy), .cmd(cmd),
    .pageMatch(pageMatch), .rdData(rdData)
  );

endmodule

// File: tb/test_pageWriteEngine.sv
module test_pageWriteEngine;

  localparam int AW = 10;
  localparam int L  = 8;
  localparam int P  = 20;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [7:0] rdData;
  logic busy, pageErr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NB];

  always #2 clk = ~clk;

  pageWriteEngine #(.ADDR_W(AW), .PAGE_W(8), .DATA_W(8), .LOAD_CYC(L), .PROG_CYC(P))
    i_pageWriteEngine (.clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
      .ceN(ceN), .oeN(oeN), .weN(weN), .rdData(rdData), .busy(busy), .pageErr(pageErr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrByte(input int a, input int d, input bit oeLow);
    @(negedge clk);
    addr = AW'(a); wrData = 8'(d); oeN = !oeLow; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
  endtask

  task automatic rdByte(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = AW'(a); ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    #1 v = rdData;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  task automatic cmpRange(input int lo, input int hi, input string tag);
    logic [7:0] v;
    for (int a = lo; a < hi; a++) begin
      rdByte(a, v);
      chk(v == model[a], tag, v, model[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int a = 0; a < NB; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(pageErr == 1'b0, "R1 pageErr", pageErr, 0);
    cmpRange(0, 16, "R1 array zero");
    // R3: no read enable gives 0
    @(negedge clk); addr = 3; #1 chk(rdData == 8'h00, "R3 idle read", rdData, 0);

    // R6: full pages, scrambled order, every page
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 256; k++) begin
        int idx, d;
        idx = (k * 37 + p * 11) & 255;
        d   = (p * 53 + idx * 7 + 1) & 255;
        wrByte(p * 256 + idx, d, 1'b0);
        model[p * 256 + idx] = 8'(d);
      end
      waitIdle();
    end
    cmpRange(0, NB, "R6 sweep");

    // R6 R7: overwrite and partial page, exact busy timing R4
    wrByte(256 + 5, 8'h3C, 1'b0);
    @(negedge clk);
    chk(busy == 1'b1, "R4 busy rise", busy, 1);
    wrByte(256 + 9, 8'h77, 1'b0);
    wrByte(256 + 5, 8'hC3, 1'b0);
    model[256 + 9] = 8'h77; model[256 + 5] = 8'hC3;
    repeat (L + P) @(negedge clk);
    chk(busy == 1'b1, "R4 busy before end", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R4 busy fall", busy, 0);
    cmpRange(0, 512, "R7 partial page");

    // R5: window boundary
    wrByte(512 + 1, 8'h11, 1'b0);
    repeat (L - 2) @(negedge clk);
    wrByte(512 + 2, 8'h22, 1'b0);
    repeat (L - 1) @(negedge clk);
    wrByte(512 + 3, 8'h33, 1'b0);
    model[512 + 1] = 8'h11; model[512 + 2] = 8'h22;
    waitIdle();
    cmpRange(512, 516, "R5 window");

    // R8: foreign page byte dropped, timing unchanged
    chk(pageErr == 1'b0, "R8 no error yet", pageErr, 0);
    wrByte(768 + 7, 8'h5A, 1'b0);
    wrByte(0 + 7, 8'hA5, 1'b0);
    model[768 + 7] = 8'h5A;
    repeat (L + P - 2) @(negedge clk);
    chk(busy == 1'b1, "R8 busy before end", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R8 busy fall unchanged", busy, 0);
    chk(pageErr == 1'b1, "R8 pageErr set", pageErr, 1);
    repeat (5) @(negedge clk);
    chk(pageErr == 1'b1, "R8 pageErr sticky", pageErr, 1);
    cmpRange(0, 16, "R8 page0 intact");
    cmpRange(768, 776, "R8 page3");

    // R9: strobes during programming ignored; R3 read blanked while busy
    wrByte(40, 8'hE1, 1'b0);
    model[40] = 8'hE1;
    repeat (L + 2) @(negedge clk);
    wrByte(41, 8'h99, 1'b0);
    wrByte(40, 8'h66, 1'b0);
    rdByte(100, v);
    chk(v == 8'h00, "R3 read while busy", v, 0);
    waitIdle();
    cmpRange(36, 46, "R9 ignored in prog");
    @(negedge clk);
    chk(busy == 1'b0, "R9 no new burst", busy, 0);

    // R2: oeN low during write stays idle and unchanged
    wrByte(60, 8'h0F, 1'b1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 oeN low no start", busy, 0);
    cmpRange(58, 62, "R2 oeN low no write");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule